// File: doc/BRIEF.md
# Serially Configured Ten-Output Clock Gate

This block receives write transactions on a two-wire serial bus (I2C, slave receiver only) and uses the bytes it receives to decide which of ten copies of a single input clock are passed through. The bus lines are oversampled with the system clock. The block acknowledges by requesting a low on the shared data line through an open-drain drive request. After a start condition and a matching device address with a write direction, the bytes that follow fill three configuration bytes in a fixed order. There is no register pointer.

Each output carries the input clock while its configuration bit is 1, and is held low while the bit is 0. A global enable input sets the active-high tri-state enables for all ten outputs together. All configuration bits come out of reset set to 1, so every output passes the clock from power-up.

Top module: `i2c_clkgate_ctrl`

## Requirements
- R1: After reset every configuration bit is 1, so all ten outputs carry `clk_in`.
- R2: The address byte 0xD2 (device address 1101001, then direction bit 0) is acknowledged. The block drives `sda_drive_low` high during the ninth clock of that byte.
- R3: An address byte with a different device address, or with direction bit 1, is not acknowledged. The data bytes that follow are neither acknowledged nor stored until the next start condition.
- R4: The first data byte after the address is stored as byte 0. Its bits 3..0 enable `clk_out[3:0]`, and its bits 7..4 are ignored.
- R5: The second data byte is stored as byte 1. Its bits 7..4 enable `clk_out[7:4]`, and its bits 3..0 are ignored.
- R6: The third data byte is stored as byte 2. Bit 6 enables `clk_out[8]` and bit 7 enables `clk_out[9]`; bits 5..0 are ignored.
- R7: Data bytes after the third are acknowledged and change no output.
- R8: Every start condition, including a repeated start without a stop, makes the next data byte land in byte 0 again.
- R9: An enabled output equals `clk_in`. A disabled output is 0 whatever the level of `clk_in`.
- R10: `out_en` is all ones while `oe` is 1 and all zeros while `oe` is 0.
- R11: A stop condition in the middle of a data byte leaves every configuration bit unchanged.
- R12: Each data byte received after an acknowledged address is acknowledged during its ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_drive_low | output | 1 | When 1, pull the data line low (acknowledge) |
| oe | input | 1 | Global output enable |
| clk_in | input | 1 | Clock to distribute |
| clk_out | output | 10 | Gated copies of `clk_in` |
| out_en | output | 10 | Tri-state enable for each output, active high |

## Verification
The hardest case to reach from the ports is an interrupted byte: a stop partway through a data byte, or a repeated start in the middle of a write sequence. Either one must discard partial data and reset the byte order. The stimulus builds these by calling the bus tasks for single bits, start and stop, so a transaction can be cut off at any bit. It then runs a complete write and reads the result back at the gated outputs, with `clk_in` held high and then low.

// File: rtl/i2c_clkgate_ctrl.sv
module i2c_clkgate_ctrl #(
  parameter logic [6:0] DEV_ADDR = 7'b1101001
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_drive_low,
  input  logic       oe,
  input  logic       clk_in,
  output logic [9:0] clk_out,
  output logic [9:0] out_en
);

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_DATA, ST_ACKW, ST_ACK} st_t;

  st_t        state;
  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  logic [2:0] bitcnt;
  logic [6:0] shreg;
  logic [1:0] idx;
  logic [3:0] en0, en1;
  logic [1:0] en2;
  logic       ack_low;

  wire scl_s    = scl_sy[1];
  wire sda_s    = sda_sy[1];
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  wire [7:0] byte_in = {shreg, sda_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      idx     <= '0;
      en0     <= '1;
      en1     <= '1;
      en2     <= '1;
      ack_low <= 1'b0;
    end else if (start_c) begin
      state   <= ST_ADDR;
      bitcnt  <= '0;
      idx     <= '0;
      ack_low <= 1'b0;
    end else if (stop_c) begin
      state   <= ST_IDLE;
      ack_low <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_DATA: if (scl_rise) begin
          shreg  <= byte_in[6:0];
          bitcnt <= bitcnt + 3'd1;
          if (bitcnt == 3'd7) begin
            if (state == ST_ADDR) begin
              state <= (byte_in == {DEV_ADDR, 1'b0}) ? ST_ACKW : ST_IDLE;
            end else begin
              state <= ST_ACKW;
              case (idx)
                2'd0:    en0 <= byte_in[3:0];
                2'd1:    en1 <= byte_in[7:4];
                2'd2:    en2 <= byte_in[7:6];
                default: ;
              endcase
              if (idx != 2'd3) idx <= idx + 2'd1;
            end
          end
        end
        ST_ACKW: if (scl_fall) begin
          ack_low <= 1'b1;
          state   <= ST_ACK;
        end
        ST_ACK: if (scl_fall) begin
          ack_low <= 1'b0;
          bitcnt  <= '0;
          state   <= ST_DATA;
        end
        default: ;
      endcase
    end
  end

  wire [9:0] en_map = {en2[1], en2[0], en1, en0};

  assign clk_out       = en_map & {10{clk_in}};
  assign out_en        = {10{oe}};
  assign sda_drive_low = ack_low;

  a_r2_ack_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_low) |-> $past(state == ST_ACKW));

  a_r12_ack_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_low) |-> $past(state == ST_ACK));

  a_r3_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !ack_low);

  a_r11_load_on_full_byte: assert property (@(posedge clk) disable iff (!rst_n)
    ({en0, en1, en2} != $past({en0, en1, en2})) |->
      $past(state == ST_DATA && bitcnt == 3'd7 && scl_rise));

  a_r8_start_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start_c) |-> (idx == 2'd0));

endmodule

// File: tb/i2c_clkgate_ctrl_bench.sv
module i2c_clkgate_ctrl_bench;
  logic clk = 0, rst_n = 0, scl = 1, sda_m = 1, oe = 1, clk_in = 0;
  logic sda_low;
  logic [9:0] clk_out, out_en;
  wire sda_line = sda_m & ~sda_low;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [9:0] exp_mask = '1;

  always #10 clk = ~clk;

  i2c_clkgate_ctrl u_i2c_clkgate_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
    .sda_drive_low(sda_low), .oe(oe), .clk_in(clk_in),
    .clk_out(clk_out), .out_en(out_en));

  task automatic check(input bit ok, input string req, input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (8) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1; q(); scl = 1; q(); sda_m = 0; q(); scl = 0; q();
  endtask

  task automatic i2c_stop();
    sda_m = 0; q(); scl = 1; q(); sda_m = 1; q();
  endtask

  task automatic i2c_bit(input bit b);
    sda_m = b; q(); scl = 1; q(); scl = 0; q();
  endtask

  task automatic i2c_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) i2c_bit(b[i]);
    sda_m = 1; q(); scl = 1; q(); acked = !sda_line; scl = 0; q();
  endtask

  task automatic chk_outs(input string req);
    @(negedge clk); clk_in = 1; #1;
    check(clk_out == exp_mask, req, clk_out, exp_mask);
    clk_in = 0; #1;
    check(clk_out == 10'd0, req, clk_out, 10'd0);
  endtask

  task automatic write_seq(input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2, input string req);
    bit a;
    i2c_start();
    i2c_byte(8'hD2, a); check(a, "R2 address ack", {9'd0, a}, 10'd1);
    i2c_byte(d0, a);    check(a, "R12 byte0 ack", {9'd0, a}, 10'd1);
    i2c_byte(d1, a);    check(a, "R12 byte1 ack", {9'd0, a}, 10'd1);
    i2c_byte(d2, a);    check(a, "R12 byte2 ack", {9'd0, a}, 10'd1);
    i2c_stop();
    exp_mask = {d2[7], d2[6], d1[7:4], d0[3:0]};
    chk_outs(req);
  endtask

  task automatic t_reset();
    exp_mask = '1;
    chk_outs("R1 reset all enabled");
    check(out_en == 10'h3FF, "R10 oe high", out_en, 10'h3FF);
  endtask

  task automatic t_three_bytes();
    write_seq(8'hF5, 8'hA0, 8'h40, "R4 R5 R6 R9 gating");
    write_seq(8'h0A, 8'h5F, 8'hBF, "R4 R5 R6 reserved ignored");
  endtask

  task automatic t_extra_bytes();
    bit a;
    write_seq(8'h0F, 8'hF0, 8'hC0, "R9 all enabled");
    i2c_start();
    i2c_byte(8'hD2, a);
    i2c_byte(8'h0F, a); i2c_byte(8'hF0, a); i2c_byte(8'hC0, a);
    i2c_byte(8'h00, a); check(a, "R7 fourth byte acked", {9'd0, a}, 10'd1);
    i2c_byte(8'h00, a); check(a, "R7 fifth byte acked", {9'd0, a}, 10'd1);
    i2c_stop();
    chk_outs("R7 extra bytes discarded");
  endtask

  task automatic t_restart();
    bit a;
    i2c_start(); i2c_byte(8'hD2, a); i2c_byte(8'h03, a); i2c_stop();
    exp_mask[3:0] = 4'h3;
    chk_outs("R8 partial sequence byte0");
    i2c_start(); i2c_byte(8'hD2, a); i2c_byte(8'h09, a);
    i2c_start(); i2c_byte(8'hD2, a); i2c_byte(8'h0C, a); i2c_stop();
    exp_mask[3:0] = 4'hC;
    chk_outs("R8 repeated start rewinds to byte0");
  endtask

  task automatic t_bad_addr();
    bit a;
    i2c_start(); i2c_byte(8'h52, a);
    check(!a, "R3 wrong address nack", {9'd0, a}, 10'd0);
    i2c_byte(8'h00, a);
    check(!a, "R3 data after nack", {9'd0, a}, 10'd0);
    i2c_stop();
    i2c_start(); i2c_byte(8'hD3, a);
    check(!a, "R3 read direction nack", {9'd0, a}, 10'd0);
    i2c_byte(8'h00, a); i2c_stop();
    chk_outs("R3 nothing stored");
  endtask

  task automatic t_stop_mid();
    bit a;
    i2c_start(); i2c_byte(8'hD2, a);
    i2c_bit(0); i2c_bit(0); i2c_bit(0); i2c_bit(0); i2c_bit(0);
    i2c_stop();
    chk_outs("R11 stop mid byte");
  endtask

  task automatic t_oe();
    oe = 0; #1;
    check(out_en == 10'h000, "R10 oe low tristate", out_en, 10'h000);
    oe = 1; #1;
    check(out_en == 10'h3FF, "R10 oe high again", out_en, 10'h3FF);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_three_bytes();
    t_extra_bytes();
    t_restart();
    t_bad_addr();
    t_stop_mid();
    t_oe();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule